// File: doc/BRIEF.md
# Wait-Sampling Bus Cycle Sequencer

This block produces the clock-by-clock timing of an 8-bit processor's memory machine cycles. It takes one command at a time from a small request port: opcode fetch, memory read or memory write, each with an address and write data. It runs the matching machine cycle and stretches it by whole clocks while the external wait input is active. It marks the one clock in which memory is actually accessed.

The wait input is looked at once per clock, from the second clock of a cycle on, standing for a sample at the falling edge in the middle of that clock. An opcode fetch makes its access in the first clock whose sample finds wait low. It then runs two refresh clocks that never look at wait. A memory read or write makes its access in the clock after the first clock whose sample finds wait low. At the end of each machine cycle a done pulse reports how many clocks the cycle took. A new request can be accepted in that final clock, so cycles can run back to back with no gap.

Top module: `wcs_bus_seq`

## Requirements
- R1: After a synchronous active-low reset, the block is idle. `req_ready_o` is 1, `acc_o`, `rfsh_o`, `done_o` and `mem_we_o` are 0, and `rd_data_o` is 0.
- R2: `req_kind_i` codes are 0 for opcode fetch, 1 for memory read, 2 for memory write. A request is taken when `req_valid_i` and `req_ready_o` are both 1 at a rising edge, and its first clock follows that edge. Code 3 is never taken: no cycle starts, and no strobe, refresh or done pulse appears.
- R3: With wait held low, an opcode fetch lasts 4 clocks. The access strobe is in clock 2, refresh is in clocks 3 and 4, and done is in clock 4 with a count of 4.
- R4: With wait held low, a read or write lasts 3 clocks. The access strobe and done are both in clock 3, with a count of 3.
- R5: Wait is looked at in clock 2 and in every added clock. Each clock in which it is found high adds one clock to the cycle, and the reported count includes these clocks. Wait in clock 1 has no effect.
- R6: An opcode fetch asserts `acc_o` in the first clock whose wait sample is low, within that same clock.
- R7: A read or write asserts `acc_o` in the clock that follows the first clock whose wait sample is low. That clock is the last clock of the cycle.
- R8: The two refresh clocks after a fetch ignore wait. They are always exactly two, and `acc_o` is 0 in both.
- R9: While `acc_o` is 1, `mem_addr_o` carries the request address. `mem_we_o` is 1 only for a write, and `mem_wdata_o` carries the write data. For a fetch or read, `mem_rdata_i` is captured into `rd_data_o` at the rising edge that ends the strobe clock. A write leaves `rd_data_o` unchanged.
- R10: `req_ready_o` is 1 while idle and in the last clock of a cycle. A request taken in that last clock starts its clock 1 on the very next clock.
- R11: `done_o` is a single-clock pulse in the last clock of every cycle. `done_clocks_o` then holds the cycle length, which saturates at 2^CNT_W-1 (63 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request can be taken this clock |
| wait_i | input | 1 | Wait request, looked at in the sampling clocks |
| acc_o | output | 1 | Memory access strobe |
| mem_addr_o | output | ADDR_W | Access address |
| mem_we_o | output | 1 | Access is a write |
| mem_wdata_o | output | DATA_W | Write data to memory |
| mem_rdata_i | input | DATA_W | Read data from memory |
| rfsh_o | output | 1 | Refresh clock after a fetch |
| done_o | output | 1 | Last clock of the machine cycle |
| done_clocks_o | output | CNT_W | Clocks used by the cycle, valid with done |
| rd_data_o | output | DATA_W | Last captured read or fetch data |

## Verification
All timings count from the rising edge that takes the request. Clock 1 is the clock after that edge. For a fetch with n wait clocks, the strobe is due in clock 2+n, refresh in the two clocks that follow, and done with count 4+n in the last of them. For a read or write, the strobe, done and count 3+n are all due in clock 3+n. Captured data is due on `rd_data_o` one edge after the strobe. The bench sets wait and the read data 1 ns after each rising edge and samples all outputs 1 ns later, so the fetch strobe, which follows wait within the clock, is seen in the clock it belongs to. The bench drives read data with the expected value only in the predicted strobe clock and with its inverse in every other clock, so a capture one edge early or late shows up as a wrong value.

// File: rtl/wcs_pkg.sv
`timescale 1ns/1ps
// Shared types for the wait-sampling bus cycle sequencer.
// Assumes: request kinds are 2-bit codes; code 3 is reserved.
package wcs_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } wcs_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FIRST  = 3'd1,
        PH_SAMPLE = 3'd2,
        PH_ACCESS = 3'd3,
        PH_REF1   = 3'd4,
        PH_REF2   = 3'd5
    } wcs_phase_e;

endpackage

// File: rtl/wcs_cmd_reg.sv
`timescale 1ns/1ps
// Command holding register: keeps kind, address and write data of the
// machine cycle in progress.
// Assumes: load_i is high only at the edge that starts a new cycle.
module wcs_cmd_reg
    import wcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  wcs_kind_e         kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output wcs_kind_e         kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    // Capture the request fields when a cycle is started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_o  <= KIND_NONE;
            addr_o  <= '0;
            wdata_o <= '0;
        end else if (load_i) begin
            kind_o  <= kind_i;
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
        end
    end

endmodule

// File: rtl/wcs_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: walks a machine cycle through first clock, wait
// sampling clocks, then an access clock (read/write) or two refresh
// clocks (fetch). Wait is only looked at in the sampling phase.
// Assumes: kind_i is the latched kind of the cycle in progress.
module wcs_phase_fsm
    import wcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  wcs_kind_e  kind_i,
    input  logic       wait_i,
    output wcs_phase_e phase_o,
    output logic       last_o
);

    wcs_phase_e phase_d;

    // Next phase from the current phase, wait and a new start.
    always_comb begin
        phase_d = phase_o;
        unique case (phase_o)
            PH_IDLE:   phase_d = load_i ? PH_FIRST : PH_IDLE;
            PH_FIRST:  phase_d = PH_SAMPLE;
            PH_SAMPLE: begin
                if (wait_i)                  phase_d = PH_SAMPLE;
                else if (kind_i == KIND_FETCH) phase_d = PH_REF1;
                else                         phase_d = PH_ACCESS;
            end
            PH_ACCESS: phase_d = load_i ? PH_FIRST : PH_IDLE;
            PH_REF1:   phase_d = PH_REF2;
            PH_REF2:   phase_d = load_i ? PH_FIRST : PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= PH_IDLE;
        else        phase_o <= phase_d;
    end

    // Final clock of a cycle: the access clock or the second refresh clock.
    always_comb last_o = (phase_o == PH_ACCESS) || (phase_o == PH_REF2);

endmodule

// File: rtl/wcs_cyc_counter.sv
`timescale 1ns/1ps
// Clock counter for the machine cycle: reads 1 in the first clock and
// k in clock k. SAT_EN selects saturation at all-ones or wrap-around.
// Assumes: load_i marks the edge before clock 1; run_i is high in cycle.
module wcs_cyc_counter #(
    parameter int CNT_W  = 6,
    parameter bit SAT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_inc;

    generate
        if (SAT_EN) begin : g_sat
            localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
            // Increment that holds at the top value.
            always_comb count_inc = (count_o == CNT_MAX) ? count_o : count_o + 1'b1;
        end else begin : g_wrap
            // Plain increment that wraps.
            always_comb count_inc = count_o + 1'b1;
        end
    endgenerate

    // Count register: restart on load, advance while a cycle runs.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_o <= '0;
        else if (load_i) count_o <= CNT_W'(1);
        else if (run_i)  count_o <= count_inc;
    end

endmodule

// File: rtl/wcs_bus_seq.sv
`timescale 1ns/1ps
// Top of the wait-sampling bus cycle sequencer. Takes fetch/read/write
// requests, runs the machine cycle timing, strobes the memory access
// and reports the clock count of each cycle.
// Assumes: wait_i is stable for the whole clock it is sampled in; the
// fetch strobe follows wait_i combinationally within the clock.
module wcs_bus_seq
    import wcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    input  logic              wait_i,
    output logic              acc_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              rfsh_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  done_clocks_o,
    output logic [DATA_W-1:0] rd_data_o
);

    wcs_kind_e         req_kind;
    wcs_kind_e         cur_kind;
    wcs_phase_e        phase;
    logic              last;
    logic              accept;
    logic              running;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    // Request decode and acceptance.
    always_comb begin
        req_kind    = wcs_kind_e'(req_kind_i);
        req_ready_o = (phase == PH_IDLE) || last;
        accept      = req_valid_i && req_ready_o && (req_kind != KIND_NONE);
        running     = (phase != PH_IDLE);
    end

    wcs_cmd_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .kind_i  (req_kind),
        .addr_i  (req_addr_i),
        .wdata_i (req_wdata_i),
        .kind_o  (cur_kind),
        .addr_o  (cur_addr),
        .wdata_o (cur_wdata)
    );

    wcs_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .kind_i  (cur_kind),
        .wait_i  (wait_i),
        .phase_o (phase),
        .last_o  (last)
    );

    wcs_cyc_counter #(
        .CNT_W  (CNT_W),
        .SAT_EN (1'b1)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .run_i   (running),
        .count_o (done_clocks_o)
    );

    // Bus outputs: strobe, direction, refresh and completion.
    always_comb begin
        acc_o       = ((phase == PH_SAMPLE) && (cur_kind == KIND_FETCH) && !wait_i)
                      || (phase == PH_ACCESS);
        mem_we_o    = acc_o && (cur_kind == KIND_WRITE);
        mem_addr_o  = cur_addr;
        mem_wdata_o = cur_wdata;
        rfsh_o      = (phase == PH_REF1) || (phase == PH_REF2);
        done_o      = last;
    end

    // Read data capture at the end of a fetch or read strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rd_data_o <= '0;
        else if (acc_o && (cur_kind != KIND_WRITE)) rd_data_o <= mem_rdata_i;
    end

endmodule

// Checker bound to the sequencer top; watches ports and the latched kind.
module wcs_bus_seq_chk
    import wcs_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_o,
    input logic             mem_we_o,
    input logic             rfsh_o,
    input logic             done_o,
    input logic             req_ready_o,
    input logic [CNT_W-1:0] done_clocks_o,
    input wcs_kind_e        cur_kind
);

    logic [1:0] seen;

    // Strobes seen so far in the current machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  seen <= '0;
        else if (done_o)             seen <= '0;
        else if (acc_o && seen != 2'd3) seen <= seen + 2'd1;
    end

    AST_WE_ONLY_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (acc_o && cur_kind == KIND_WRITE)); // R9
    AST_ONE_STROBE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((seen == 2'd0 && acc_o) || (seen == 2'd1 && !acc_o))); // R11
    AST_NO_STROBE_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_o |-> !acc_o); // R8
    AST_REFRESH_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_o && !done_o) |=> (rfsh_o && done_o)); // R8
    AST_FETCH_STROBE_THEN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && cur_kind == KIND_FETCH) |=> (rfsh_o && !done_o)); // R6
    AST_RW_STROBE_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && cur_kind != KIND_FETCH) |-> done_o); // R7
    AST_FETCH_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cur_kind == KIND_FETCH) |-> (done_clocks_o >= CNT_W'(4))); // R3
    AST_RW_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cur_kind != KIND_FETCH) |-> (done_clocks_o >= CNT_W'(3))); // R4
    AST_READY_IN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready_o); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

endmodule

bind wcs_bus_seq wcs_bus_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_o         (acc_o),
    .mem_we_o      (mem_we_o),
    .rfsh_o        (rfsh_o),
    .done_o        (done_o),
    .req_ready_o   (req_ready_o),
    .done_clocks_o (done_clocks_o),
    .cur_kind      (cur_kind)
);

// File: tb/tb_wcs_bus_seq.sv
`timescale 1ns/1ps
// Directed bench for the bus cycle sequencer: one task per scenario.
module tb_wcs_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd3;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        wait_i = 1'b0;
    logic        acc;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        rfsh;
    logic        done;
    logic [5:0]  cycles;
    logic [7:0]  rd_data;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    logic [7:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    wcs_bus_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_kind_i    (req_kind),
        .req_addr_i    (req_addr),
        .req_wdata_i   (req_wdata),
        .req_ready_o   (req_ready),
        .wait_i        (wait_i),
        .acc_o         (acc),
        .mem_addr_o    (mem_addr),
        .mem_we_o      (mem_we),
        .mem_wdata_o   (mem_wdata),
        .mem_rdata_i   (mem_rdata),
        .rfsh_o        (rfsh),
        .done_o        (done),
        .done_clocks_o (cycles),
        .rd_data_o     (rd_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report_end();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One machine cycle with n wait clocks; optional wait noise in the
    // clocks that must ignore wait; optional chained next request.
    task automatic run_cycle(input logic [1:0] kind, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] rdv,
                             input int nwait, input bit noise, input bit skip_req,
                             input bit chain, input logic [1:0] nkind,
                             input logic [15:0] naddr, input logic [7:0] nwd);
        bit    is_fetch;
        int    acc_clk;
        int    total;
        int    expcnt;
        string len_tag;
        is_fetch = (kind == 2'd0);
        acc_clk  = is_fetch ? 2 + nwait : 3 + nwait;
        total    = is_fetch ? 4 + nwait : 3 + nwait;
        expcnt   = (total > 63) ? 63 : total;
        if (total > 63)      len_tag = "R11 saturated count";
        else if (nwait > 0)  len_tag = "R5 stretched length";
        else if (is_fetch)   len_tag = "R3 fetch length";
        else                 len_tag = "R4 read/write length";
        if (!skip_req) begin
            req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
            #1;
            chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
            @(posedge clk); #1;
            req_valid = 1'b0; req_kind = 2'd3;
        end
        for (int k = 1; k <= total; k++) begin
            if (k >= 2 && k <= 2 + nwait) wait_i = (k < 2 + nwait);
            else                         wait_i = noise;
            mem_rdata = (k == acc_clk) ? rdv : ~rdv;
            if (chain && k == total) begin
                req_valid = 1'b1; req_kind = nkind; req_addr = naddr; req_wdata = nwd;
            end
            #1;
            if (is_fetch) chk(acc == (k == acc_clk), "R6 fetch strobe clock", acc, k == acc_clk);
            else          chk(acc == (k == acc_clk), "R7 read/write strobe clock", acc, k == acc_clk);
            chk(rfsh == (is_fetch && k > total - 2), "R8 refresh clocks", rfsh, is_fetch && k > total - 2);
            chk(done == (k == total), "R11 done pulse", done, k == total);
            if (k == total) begin
                chk(cycles == expcnt, len_tag, cycles, expcnt);
                chk(req_ready == 1'b1, "R10 ready in last clock", req_ready, 1);
            end
            if (k == acc_clk) begin
                chk(mem_addr == addr, "R9 strobe address", mem_addr, addr);
                chk(mem_we == (kind == 2'd2), "R9 strobe direction", mem_we, kind == 2'd2);
                if (kind == 2'd2) chk(mem_wdata == wd, "R9 write data", mem_wdata, wd);
            end else begin
                chk(mem_we == 1'b0, "R9 no write outside strobe", mem_we, 0);
            end
            @(posedge clk); #1;
            if (chain && k == total) begin
                req_valid = 1'b0; req_kind = 2'd3;
            end
        end
        wait_i = 1'b0;
        if (kind != 2'd2) exp_rd = rdv;
        chk(rd_data == exp_rd, "R9 captured read data", rd_data, exp_rd);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(acc == 1'b0, "R1 no strobe after reset", acc, 0);
        chk(rfsh == 1'b0, "R1 no refresh after reset", rfsh, 0);
        chk(done == 1'b0, "R1 no done after reset", done, 0);
        chk(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);
        chk(rd_data == 8'd0, "R1 read data after reset", rd_data, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_reserved_ignored();
        req_valid = 1'b1; req_kind = 2'd3; req_addr = 16'h7777;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(acc == 1'b0, "R2 reserved code gives no strobe", acc, 0);
            chk(rfsh == 1'b0, "R2 reserved code gives no refresh", rfsh, 0);
            chk(done == 1'b0, "R2 reserved code gives no done", done, 0);
            chk(req_ready == 1'b1, "R2 still idle", req_ready, 1);
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
        run_cycle(2'd1, 16'h0102, 8'h00, 8'h5A, 0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);
    endtask

    task automatic t_back_to_back();
        run_cycle(2'd1, 16'h1000, 8'h00, 8'hC3, 0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h1001, 8'h00);
        run_cycle(2'd0, 16'h1001, 8'h00, 8'h3C, 1, 1'b0, 1'b1, 1'b1, 2'd2, 16'h1002, 8'h99);
        run_cycle(2'd2, 16'h1002, 8'h99, 8'h11, 0, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0, 8'h0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report_end();
    end

    initial begin
        t_reset();                                                                         // R1
        run_cycle(2'd0, 16'hA001, 8'h00, 8'h3E, 0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R3
        run_cycle(2'd1, 16'hB002, 8'h00, 8'h81, 0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R4
        run_cycle(2'd2, 16'hC003, 8'h6D, 8'h42, 0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R4 R9
        run_cycle(2'd0, 16'h0F10, 8'h00, 8'hE7, 2, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R5 R6
        run_cycle(2'd1, 16'h2222, 8'h00, 8'h19, 3, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R5 R7
        run_cycle(2'd2, 16'h3333, 8'hF0, 8'h0F, 1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R5 noise
        run_cycle(2'd0, 16'h4444, 8'h00, 8'hAA, 1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R8
        run_cycle(2'd1, 16'h5555, 8'h00, 8'h66, 0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);   // R5 clock 1
        t_reserved_ignored();                                                              // R2
        t_back_to_back();                                                                  // R10
        run_cycle(2'd0, 16'h6666, 8'h00, 8'hD2, 70, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 8'h0);  // R11
        report_end();
    end

endmodule